// File: doc/BRIEF.md
# Shared-Adder Multichannel Sigma-Delta DAC

This block produces first-order sigma-delta bitstreams for a bank of channels. It uses one adder. Every channel keeps an 8-bit setpoint and an 8-bit accumulator in a small register file. A sequencer visits the channels in round-robin order, one channel per clock. In the visit it adds the channel's setpoint to the channel's accumulator, writes the low bits back and takes the carry-out as that channel's output bit. The bits are gathered into a working word. When the sweep ends, the word is copied to the output port register in one step, so all single-bit outputs change on the same edge, once every N_CH clocks. An analog low-pass filter after each pin (not part of this block) turns the bit density into a DC level equal to setpoint/256.

A setpoint can be rewritten at any time through a one-cycle write strobe. The modulators keep running while this happens. Each channel's bitstream is the same one a dedicated per-channel modulator would produce, clocked at the core rate divided by N_CH.

The sequencer is a three-state machine:
- ST_IDLE is entered on reset. It leaves on the first clock without reset, which is the transition *start*, to ST_SERVE at channel 0.
- ST_SERVE serves channels 0 to N_CH-2. The transition *step* stays in ST_SERVE and moves to the next channel. The transition *enter_last* goes to ST_LAST when channel N_CH-2 has been served.
- ST_LAST serves channel N_CH-1 and publishes the word. The transition *wrap* then returns to ST_SERVE at channel 0.

Top module: `sdm_mux_dac`

## Requirements
- R1: When channel c is served, the block computes acc[c] + sp[c] in 9 bits. The low 8 bits become the new acc[c]. Bit 8 (the carry) is the channel's output bit for that sweep.
- R2: Channel i drives bit i of `dac_out`. The number of channels is the parameter N_CH (default 8, at least 2).
- R3: The channels are served in the order 0, 1, …, N_CH-1, one per clock, and then the order repeats. The first clock edge with reset low only starts the sequencer. Channel 0 is served on the second such edge.
- R4: `dac_out` changes only on the edge on which channel N_CH-1 is served. On that edge it takes all N_CH carries of the sweep that just ended together. The working word is cleared at the start of every sweep.
- R5: With constant setpoints, bit i of `dac_out` is 1 in exactly sp[i] of any 256 consecutive sweeps. A setpoint of 0 never gives a 1, and a setpoint of 255 gives 255 ones.
- R6: A write with `wr_en`=1 stores `wr_value` as the setpoint of channel `wr_chan` at the clock edge. The channel uses the new value from its next service after that edge. If the write edge is also the edge on which that channel is served, the old value is used for that service. A write never changes an accumulator.
- R7: Synchronous reset (`rst`=1) clears every accumulator, every setpoint, the working word and `dac_out` to zero. Reset takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Setpoint write strobe |
| wr_chan | input | $clog2(N_CH) | Channel whose setpoint is written |
| wr_value | input | 8 | New setpoint, 0 to 255 |
| dac_out | output | N_CH | One sigma-delta bit per channel, updated once per sweep |

## Verification
A behavioural model in the bench is compared with `dac_out` on every clock. It uses the write timing of R6 as specified, including writes that land on the channel's own service edge. A design that used the new value too early, or that cleared the accumulator on a write, would drift from the model at once.

The bench watches every change of `dac_out`. A port that updated per channel, and not once per sweep, would be reported under R4.

Over 256 sweeps the bench counts the ones on every channel, with setpoints that include 0 and 255. A carry taken from the wrong bit, or a missing wrap of the accumulator, would make the count differ from the setpoint.

Reset is applied while the block is running, to show that no accumulator residue survives it.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // after reset, nothing served yet
        ST_SERVE = 2'd1,   // serving channels 0 .. N_CH-2
        ST_LAST  = 2'd2    // serving channel N_CH-1 and publishing the word
    } seq_state_t;

endpackage

// File: rtl/sdm_seq.sv
module sdm_seq
    import sdm_pkg::*;
#(
    parameter int N_CH = 8,
    parameter int CW   = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    output logic          serve,
    output logic          first,
    output logic          last,
    output logic [CW-1:0] chan
);

    localparam logic [CW-1:0] CH_PENULT = CW'(N_CH - 2);

    seq_state_t    state_q, state_d;
    logic [CW-1:0] ch_q, ch_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        ch_d    = ch_q;
        unique case (state_q)
            ST_IDLE: begin                         // start
                state_d = ST_SERVE;
                ch_d    = '0;
            end
            ST_SERVE: begin
                ch_d = ch_q + CW'(1);
                if (ch_q == CH_PENULT) begin
                    state_d = ST_LAST;             // enter_last
                end else begin
                    state_d = ST_SERVE;            // step
                end
            end
            ST_LAST: begin                         // wrap
                state_d = ST_SERVE;
                ch_d    = '0;
            end
            default: begin
                state_d = ST_IDLE;
                ch_d    = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ch_q    <= '0;
        end else begin
            state_q <= state_d;
            ch_q    <= ch_d;
        end
    end

    // Outputs
    always_comb begin
        serve = 1'b0;
        last  = 1'b0;
        unique case (state_q)
            ST_IDLE:  serve = 1'b0;
            ST_SERVE: serve = 1'b1;
            ST_LAST: begin
                serve = 1'b1;
                last  = 1'b1;
            end
            default:  serve = 1'b0;
        endcase
        first = serve && (ch_q == '0);
        chan  = ch_q;
    end

    // R3: inside ST_SERVE the channel advances by exactly one
    p_step_order_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SERVE) |=> (ch_q == $past(ch_q) + CW'(1)));

    // R3: after the last channel the sweep restarts at channel 0
    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LAST) |=> (state_q == ST_SERVE && ch_q == '0));

endmodule

// File: rtl/sdm_store.sv
module sdm_store #(
    parameter int N_CH = 8,
    parameter int W    = 8,
    parameter int CW   = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    // setpoint write port
    input  logic          wr_en,
    input  logic [CW-1:0] wr_chan,
    input  logic [W-1:0]  wr_value,
    // service port
    input  logic [CW-1:0] rd_chan,
    output logic [W-1:0]  rd_sp,
    output logic [W-1:0]  rd_acc,
    input  logic          acc_we,
    input  logic [W-1:0]  acc_new
);

    logic [W-1:0] sp_q  [N_CH];
    logic [W-1:0] acc_q [N_CH];

    for (genvar i = 0; i < N_CH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                sp_q[i]  <= '0;
                acc_q[i] <= '0;
            end else begin
                if (wr_en && (wr_chan == CW'(i))) begin
                    sp_q[i] <= wr_value;
                end
                if (acc_we && (rd_chan == CW'(i))) begin
                    acc_q[i] <= acc_new;
                end
            end
        end
    end

    always_comb begin
        rd_sp  = '0;
        rd_acc = '0;
        for (int k = 0; k < N_CH; k++) begin
            if (rd_chan == CW'(k)) begin
                rd_sp  = sp_q[k];
                rd_acc = acc_q[k];
            end
        end
    end

    // R6: a write lands in the addressed setpoint entry on its edge
    p_write_lands_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (sp_q[$past(wr_chan)] == $past(wr_value)));

endmodule

// File: rtl/sdm_adder.sv
module sdm_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] acc,
    input  logic [W-1:0] sp,
    output logic [W-1:0] sum,
    output logic         carry
);

    logic [W:0] wide;

    always_comb begin
        wide  = {1'b0, acc} + {1'b0, sp};
        sum   = wide[W-1:0];
        carry = wide[W];
    end

endmodule

// File: rtl/sdm_word.sv
module sdm_word #(
    parameter int N_CH = 8,
    parameter int CW   = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            serve,
    input  logic            first,
    input  logic            last,
    input  logic [CW-1:0]   chan,
    input  logic            bit_in,
    output logic [N_CH-1:0] port
);

    logic [N_CH-1:0] work_q;
    logic [N_CH-1:0] port_q;
    logic [N_CH-1:0] merged;

    for (genvar i = 0; i < N_CH; i++) begin : g_bit
        // working word: clear at sweep start, fill the served bit
        always_ff @(posedge clk) begin
            if (rst) begin
                work_q[i] <= 1'b0;
            end else if (serve && (chan == CW'(i))) begin
                work_q[i] <= bit_in;
            end else if (first) begin
                work_q[i] <= 1'b0;
            end
        end
        assign merged[i] = (chan == CW'(i)) ? bit_in : work_q[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            port_q <= '0;
        end else if (last) begin
            port_q <= merged;
        end
    end

    assign port = port_q;

    // R4: the port holds its value unless the last channel is served
    p_port_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !last |=> $stable(port_q));

endmodule

// File: rtl/sdm_mux_dac.sv
module sdm_mux_dac #(
    parameter int N_CH = 8
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic                                    wr_en,
    input  logic [((N_CH > 1) ? $clog2(N_CH) : 1)-1:0] wr_chan,
    input  logic [7:0]                              wr_value,
    output logic [N_CH-1:0]                         dac_out
);

    localparam int W  = 8;
    localparam int CW = (N_CH > 1) ? $clog2(N_CH) : 1;

    logic          serve, first, last;
    logic [CW-1:0] chan;
    logic [W-1:0]  rd_sp, rd_acc, sum;
    logic          carry;

    sdm_seq #(.N_CH(N_CH), .CW(CW)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .serve (serve),
        .first (first),
        .last  (last),
        .chan  (chan)
    );

    sdm_store #(.N_CH(N_CH), .W(W), .CW(CW)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_chan  (wr_chan),
        .wr_value (wr_value),
        .rd_chan  (chan),
        .rd_sp    (rd_sp),
        .rd_acc   (rd_acc),
        .acc_we   (serve),
        .acc_new  (sum)
    );

    sdm_adder #(.W(W)) u_add (
        .acc   (rd_acc),
        .sp    (rd_sp),
        .sum   (sum),
        .carry (carry)
    );

    sdm_word #(.N_CH(N_CH), .CW(CW)) u_word (
        .clk    (clk),
        .rst    (rst),
        .serve  (serve),
        .first  (first),
        .last   (last),
        .chan   (chan),
        .bit_in (carry),
        .port   (dac_out)
    );

    // R5: a zero setpoint never yields a carry
    p_zero_sp_r5: assert property (@(posedge clk) disable iff (rst)
        (serve && rd_sp == '0) |-> !carry);

endmodule

// File: tb/sdm_mux_dac_tb.sv
module sdm_mux_dac_tb_top;

    localparam int N  = 8;
    localparam int CW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [CW-1:0] wr_chan = '0;
    logic [7:0]    wr_value = '0;
    logic [N-1:0]  dac_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #10 clk = ~clk;   // 50 MHz

    sdm_mux_dac #(.N_CH(N)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_chan(wr_chan),
        .wr_value(wr_value), .dac_out(dac_out)
    );

    // ---------------- behavioural reference ----------------
    int       m_acc [N];
    int       m_sp  [N];
    bit       m_work [N];
    logic [N-1:0] m_port;
    bit       m_idle;
    int       m_ch;
    bit       m_pub;
    bit       m_rst;

    always @(posedge clk) begin
        m_pub = 0;
        m_rst = rst;
        if (rst) begin
            m_idle = 1; m_ch = 0; m_port = '0;
            for (int i = 0; i < N; i++) begin
                m_acc[i] = 0; m_sp[i] = 0; m_work[i] = 0;
            end
        end else begin
            if (m_idle) begin
                m_idle = 0; m_ch = 0;
            end else begin
                int s;
                s = m_acc[m_ch] + m_sp[m_ch];
                if (m_ch == 0) for (int i = 0; i < N; i++) m_work[i] = 0;
                m_work[m_ch] = (s >= 256);
                m_acc[m_ch]  = s % 256;
                if (m_ch == N - 1) begin
                    for (int i = 0; i < N; i++) m_port[i] = m_work[i];
                    m_pub = 1;
                    m_ch  = 0;
                end else begin
                    m_ch++;
                end
            end
            if (wr_en) m_sp[wr_chan] = wr_value;   // old value used this edge
        end
    end

    // ---------------- per-clock comparison ----------------
    logic [N-1:0] prev_out = '0;
    bit           cmp_on = 0;

    always @(negedge clk) begin
        if (cmp_on) begin
            n_tests++;
            if (dac_out !== m_port) begin
                n_fail++;
                $display("FAIL R1 R2 R3 R6: dac_out=%b expected %b", dac_out, m_port);
            end
            n_tests++;
            if (dac_out !== prev_out && !m_pub && !m_rst) begin
                n_fail++;
                $display("FAIL R4: dac_out changed off sweep edge, actual %b expected %b",
                         dac_out, prev_out);
            end
        end
        prev_out = dac_out;
    end

    // ---------------- ones counting ----------------
    bit counting = 0;
    int sweeps   = 0;
    int ones [N];

    always @(negedge clk) begin
        if (counting && m_pub && sweeps < 256) begin
            for (int i = 0; i < N; i++) ones[i] += int'(dac_out[i]);
            sweeps++;
        end
    end

    task automatic write_sp(input int ch, input int v);
        @(negedge clk);
        wr_en = 1; wr_chan = CW'(ch); wr_value = 8'(v);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic count_run(input int exp_sp [N]);
        for (int i = 0; i < N; i++) ones[i] = 0;
        sweeps = 0;
        counting = 1;
        while (sweeps < 256) @(negedge clk);
        counting = 0;
        for (int i = 0; i < N; i++) begin
            n_tests++;
            if (ones[i] != exp_sp[i]) begin
                n_fail++;
                $display("FAIL R5: ch%0d ones=%0d expected %0d", i, ones[i], exp_sp[i]);
            end
        end
    endtask

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: cycles=%0d expected < 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        int sp_a [N] = '{0, 255, 1, 128, 64, 3, 200, 17};
        int sp_b [N] = '{255, 0, 254, 2, 127, 129, 85, 170};

        repeat (3) @(negedge clk);
        n_tests++;
        if (dac_out !== '0) begin
            n_fail++;
            $display("FAIL R7: reset dac_out=%b expected 0", dac_out);
        end
        rst = 0;
        cmp_on = 1;

        // R3: sequencer starts, first sweep publishes after N+1 edges
        for (int i = 0; i < N; i++) write_sp(i, sp_a[i]);
        repeat (3 * N) @(negedge clk);
        count_run(sp_a);                           // R5 pattern A

        // R6: writes landing in every position of the sweep
        for (int k = 0; k < 3 * N; k++) begin
            @(negedge clk);
            wr_en = 1; wr_chan = CW'(k % N); wr_value = 8'(37 * k + 5);
        end
        @(negedge clk); wr_en = 0;

        // R6: random writes over many sweeps, model compared every clock
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            wr_en    = ($urandom_range(0, 3) == 0);
            wr_chan  = CW'($urandom_range(0, N - 1));
            wr_value = 8'($urandom_range(0, 255));
        end
        @(negedge clk); wr_en = 0;

        // R5 pattern B, written one by one mid-sweep
        for (int i = 0; i < N; i++) write_sp(N - 1 - i, sp_b[N - 1 - i]);
        repeat (2 * N) @(negedge clk);
        count_run(sp_b);

        // R7: reset while running, write in same cycle is discarded
        @(negedge clk);
        rst = 1; wr_en = 1; wr_chan = '0; wr_value = 8'd200;
        @(negedge clk);
        wr_en = 0;
        @(negedge clk);
        n_tests++;
        if (dac_out !== '0) begin
            n_fail++;
            $display("FAIL R7: dac_out after reset=%b expected 0", dac_out);
        end
        rst = 0;
        repeat (4 * N) @(negedge clk);
        n_tests++;
        if (dac_out !== '0) begin
            n_fail++;
            $display("FAIL R7: setpoints not cleared, dac_out=%b expected 0", dac_out);
        end

        // R2: single channel lit, only its bit toggles
        write_sp(5, 255);
        repeat (N + 2) @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            repeat (N) @(negedge clk);
            n_tests++;
            if ((dac_out & ~(N'(1) << 5)) !== '0) begin
                n_fail++;
                $display("FAIL R2: dac_out=%b expected only bit 5", dac_out);
            end
        end

        repeat (N) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule